// File: doc/BRIEF.md
# Bus show-cycle mirroring controller

This block sits between a fast local bus and a slower unified bus. It copies chosen local-bus accesses onto the unified bus as show cycles, so that debug equipment on the unified bus can watch traffic that would otherwise stay inside the local bus. A 2-bit mode field picks which accesses are copied. It can copy all reads and writes or only writes. The other two codes turn copying off, and the field resets to "off".

While the block is handling an access it holds the local bus so that no other master can begin a cycle. Only one access is ever in flight. An access that the slave retries is not captured. The block keeps the bus for one more clock and then lets go, and it captures the access only when a later attempt is acknowledged. A captured access is stored in a single-entry holding register. The block requests the unified bus for at least two clocks and then runs the address phase and the data phase itself, acting as the slave. The unified-bus side can refuse a show cycle with a no-show indicator. The block then drops its request for one clock and tries again.

Top module: `showcyc_mirror`

## Requirements
- R1: After reset, lb_hold, ub_req, ub_aphase and ub_dphase are low and the mode field is 11, so a local access raises neither lb_hold nor ub_req until the field is written.
- R2: In mode 00 every acknowledged read and write is shown once. ub_aphase carries its address, direction (ub_we=1 for a write) and size. The next ub_dphase carries the data sampled on lb_dack. Shows come out in access order.
- R3: In mode 01 writes are shown and reads are not. A read acknowledged in its first cycle never raises lb_hold. A read whose acknowledge is late holds the bus only until that acknowledge.
- R4: Mode codes 10 and 11 show nothing and never raise lb_hold.
- R5: lb_hold stays high through every ub_req, ub_aphase and ub_dphase cycle of a show. It falls in the clock after ub_dphase.
- R6: An access ended with lb_retry instead of lb_aack is not shown. lb_hold stays high for exactly one clock after the retry and is then low.
- R7: ub_req is high for at least the two clocks right before each ub_aphase.
- R8: ub_dphase follows an accepted ub_aphase in the very next clock, and the payload stays stable across both.
- R9: If ub_noshow is high while ub_req or ub_aphase is high, the next clock has both low. The same entry is then requested again and shown later.
- R10: A mode write applies only to accesses that start after it. A show already captured completes normally.
- R11: This case has a one-clock local access (lb_valid, lb_aack and lb_dack together) and ub_gnt held high. ub_aphase is high after the third rising edge, counting the edge that samples the acknowledge. ub_dphase is high after the fourth edge, and lb_hold is low after the fifth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the mode field |
| cfg_mode | input | 2 | Mode value: 00 all, 01 writes, 10/11 off |
| lb_valid | input | 1 | Local access in progress (a rise marks its start) |
| lb_we | input | 1 | Local access is a write |
| lb_size | input | SIZE_W | Local access size code |
| lb_addr | input | ADDR_W | Local access address |
| lb_data | input | DATA_W | Local data (write or read data) |
| lb_aack | input | 1 | Local address acknowledge |
| lb_dack | input | 1 | Local data acknowledge |
| lb_retry | input | 1 | Slave ends address phase without acknowledge |
| lb_hold | output | 1 | Block owns the local bus; others may not start |
| ub_gnt | input | 1 | Unified-bus grant |
| ub_noshow | input | 1 | Unified side refuses the show cycle |
| ub_req | output | 1 | Unified-bus request |
| ub_aphase | output | 1 | Show address phase (self-acknowledged) |
| ub_dphase | output | 1 | Show data phase (self-terminated) |
| ub_addr | output | ADDR_W | Shown address |
| ub_we | output | 1 | Shown direction |
| ub_size | output | SIZE_W | Shown size |
| ub_data | output | DATA_W | Shown data |

## Verification
The bench builds the block with 16-bit address and data, a 2-bit size and the minimum request length of two clocks. The narrow widths keep the random payloads short while every bit still toggles. The two-clock request makes the shortest path exact, so the five-clock sequence of R11 can be checked edge by edge. Random grant and no-show timing, random acknowledge delays and retries, and mode changes between accesses reach the refusal of an address phase, late local acknowledges, and mode writes that land while a show is still pending.

// File: rtl/showcyc_pkg.sv
package showcyc_pkg;

    typedef enum logic [1:0] {
        MODE_ALL  = 2'b00,
        MODE_WR   = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_OFF  = 2'b11
    } show_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LADDR,
        ST_LDATA,
        ST_RETRY,
        ST_UREQ,
        ST_UBACK,
        ST_UADDR,
        ST_UDATA
    } seq_state_e;

    function automatic logic mode_enabled(input show_mode_e m);
        return (m == MODE_ALL) || (m == MODE_WR);
    endfunction

    function automatic logic mode_shows(input show_mode_e m, input logic is_wr);
        case (m)
            MODE_ALL: return 1'b1;
            MODE_WR:  return is_wr;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/showcyc_cfg.sv
module showcyc_cfg
    import showcyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] wdata,
    output show_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_OFF;
        end else if (we) begin
            mode <= show_mode_e'(wdata);
        end
    end
endmodule

// File: rtl/showcyc_entry.sv
module showcyc_entry #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_addr,
    input  logic              load_data,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_we,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_we,
    output logic [SIZE_W-1:0] out_size,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [SIZE_W-1:0] size;
    } hdr_t;

    hdr_t              hdr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q  <= '0;
            data_q <= '0;
        end else begin
            if (load_addr) begin
                hdr_q <= '{addr: in_addr, we: in_we, size: in_size};
            end
            if (load_data) begin
                data_q <= in_data;
            end
        end
    end

    assign out_addr = hdr_q.addr;
    assign out_we   = hdr_q.we;
    assign out_size = hdr_q.size;
    assign out_data = data_q;
endmodule

// File: rtl/showcyc_fsm.sv
module showcyc_fsm
    import showcyc_pkg::*;
#(
    parameter int REQ_MIN = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  show_mode_e mode,
    input  logic       lb_valid,
    input  logic       lb_we,
    input  logic       lb_aack,
    input  logic       lb_dack,
    input  logic       lb_retry,
    input  logic       ub_gnt,
    input  logic       ub_noshow,
    output seq_state_e st,
    output logic       load_addr,
    output logic       load_data,
    output logic       lb_hold,
    output logic       ub_req,
    output logic       ub_aphase,
    output logic       ub_dphase
);
    localparam int CNT_W = $clog2(REQ_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REQ_MIN - 1);

    seq_state_e       nxt;
    show_mode_e       mode_lat;
    show_mode_e       eff_mode;
    logic             valid_q;
    logic             start;
    logic [CNT_W-1:0] req_cnt;
    logic             req_done;

    assign start    = lb_valid && !valid_q;
    assign eff_mode = (st == ST_IDLE) ? mode : mode_lat;
    assign req_done = (req_cnt >= CNT_LAST);

    always_comb begin
        nxt       = st;
        load_addr = 1'b0;
        load_data = 1'b0;
        case (st)
            ST_IDLE, ST_LADDR: begin
                if ((st == ST_LADDR) || (start && mode_enabled(mode))) begin
                    if (lb_retry) begin
                        nxt = ST_RETRY;
                    end else if (lb_aack) begin
                        if (mode_shows(eff_mode, lb_we)) begin
                            load_addr = 1'b1;
                            if (lb_dack) begin
                                load_data = 1'b1;
                                nxt       = ST_UREQ;
                            end else begin
                                nxt = ST_LDATA;
                            end
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end else begin
                        nxt = ST_LADDR;
                    end
                end
            end
            ST_LDATA: begin
                if (lb_dack) begin
                    load_data = 1'b1;
                    nxt       = ST_UREQ;
                end
            end
            ST_RETRY: nxt = ST_IDLE;
            ST_UREQ: begin
                if (ub_noshow) begin
                    nxt = ST_UBACK;
                end else if (ub_gnt && req_done) begin
                    nxt = ST_UADDR;
                end
            end
            ST_UBACK: nxt = ST_UREQ;
            ST_UADDR: nxt = ub_noshow ? ST_UBACK : ST_UDATA;
            ST_UDATA: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            mode_lat <= MODE_OFF;
            valid_q  <= 1'b0;
            req_cnt  <= '0;
        end else begin
            st      <= nxt;
            valid_q <= lb_valid;
            if (st == ST_IDLE) begin
                mode_lat <= mode;
            end
            if (st != ST_UREQ) begin
                req_cnt <= '0;
            end else if (!req_done) begin
                req_cnt <= req_cnt + 1'b1;
            end
        end
    end

    assign lb_hold   = (st != ST_IDLE);
    assign ub_req    = (st == ST_UREQ);
    assign ub_aphase = (st == ST_UADDR);
    assign ub_dphase = (st == ST_UDATA);
endmodule

// File: rtl/showcyc_mirror.sv
module showcyc_mirror
    import showcyc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SIZE_W  = 2,
    parameter int REQ_MIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic              lb_valid,
    input  logic              lb_we,
    input  logic [SIZE_W-1:0] lb_size,
    input  logic [ADDR_W-1:0] lb_addr,
    input  logic [DATA_W-1:0] lb_data,
    input  logic              lb_aack,
    input  logic              lb_dack,
    input  logic              lb_retry,
    output logic              lb_hold,
    input  logic              ub_gnt,
    input  logic              ub_noshow,
    output logic              ub_req,
    output logic              ub_aphase,
    output logic              ub_dphase,
    output logic [ADDR_W-1:0] ub_addr,
    output logic              ub_we,
    output logic [SIZE_W-1:0] ub_size,
    output logic [DATA_W-1:0] ub_data
);
    show_mode_e mode;
    seq_state_e seq_st;
    logic       load_addr;
    logic       load_data;

    showcyc_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_mode),
        .mode  (mode)
    );

    showcyc_fsm #(.REQ_MIN(REQ_MIN)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .lb_valid  (lb_valid),
        .lb_we     (lb_we),
        .lb_aack   (lb_aack),
        .lb_dack   (lb_dack),
        .lb_retry  (lb_retry),
        .ub_gnt    (ub_gnt),
        .ub_noshow (ub_noshow),
        .st        (seq_st),
        .load_addr (load_addr),
        .load_data (load_data),
        .lb_hold   (lb_hold),
        .ub_req    (ub_req),
        .ub_aphase (ub_aphase),
        .ub_dphase (ub_dphase)
    );

    showcyc_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_entry (
        .clk       (clk),
        .rst       (rst),
        .load_addr (load_addr),
        .load_data (load_data),
        .in_addr   (lb_addr),
        .in_we     (lb_we),
        .in_size   (lb_size),
        .in_data   (lb_data),
        .out_addr  (ub_addr),
        .out_we    (ub_we),
        .out_size  (ub_size),
        .out_data  (ub_data)
    );
endmodule

// File: rtl/showcyc_chk.sv
module showcyc_chk
    import showcyc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lb_retry,
    input logic              lb_hold,
    input logic              ub_req,
    input logic              ub_noshow,
    input logic              ub_aphase,
    input logic              ub_dphase,
    input logic [ADDR_W-1:0] ub_addr,
    input logic [DATA_W-1:0] ub_data,
    input seq_state_e        st
);
    p_req_two_clocks_r7: assert property (@(posedge clk) disable iff (rst)
        ub_aphase |-> ($past(ub_req) && $past(ub_req, 2)));

    p_dphase_follows_r8: assert property (@(posedge clk) disable iff (rst)
        (ub_aphase && !ub_noshow) |=> ub_dphase);

    p_payload_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (ub_aphase && !ub_noshow) |=> ($stable(ub_addr) && $stable(ub_data)));

    p_hold_covers_show_r5: assert property (@(posedge clk) disable iff (rst)
        (ub_req || ub_aphase || ub_dphase) |-> lb_hold);

    p_release_after_show_r5: assert property (@(posedge clk) disable iff (rst)
        ub_dphase |=> !lb_hold);

    p_backoff_r9: assert property (@(posedge clk) disable iff (rst)
        ((ub_req || ub_aphase) && ub_noshow) |=> (!ub_req && !ub_aphase));

    p_retry_release_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LADDR && lb_retry) |=> lb_hold ##1 !lb_hold);
endmodule

bind showcyc_mirror showcyc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lb_retry  (lb_retry),
    .lb_hold   (lb_hold),
    .ub_req    (ub_req),
    .ub_noshow (ub_noshow),
    .ub_aphase (ub_aphase),
    .ub_dphase (ub_dphase),
    .ub_addr   (ub_addr),
    .ub_data   (ub_data),
    .st        (seq_st)
);

// File: tb/sim_showcyc_mirror.sv
module sim_showcyc_mirror;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          lb_valid = 1'b0, lb_we = 1'b0, lb_aack = 1'b0, lb_dack = 1'b0, lb_retry = 1'b0;
    logic [SW-1:0] lb_size = '0;
    logic [AW-1:0] lb_addr = '0;
    logic [DW-1:0] lb_data = '0;
    logic          lb_hold;
    logic          ub_gnt = 1'b0, ub_noshow = 1'b0;
    logic          ub_req, ub_aphase, ub_dphase, ub_we;
    logic [AW-1:0] ub_addr;
    logic [SW-1:0] ub_size;
    logic [DW-1:0] ub_data;

    typedef struct {
        logic [AW-1:0] a;
        logic          we;
        logic [SW-1:0] sz;
        logic [DW-1:0] d;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   n_tests = 0, n_fail = 0;
    int   hold_cycles = 0, req_run = 0;
    bit   bus_rand = 1'b0, dpend = 1'b0, prev_ns = 1'b0;
    logic [1:0] mode_model = 2'b11;

    always #5 clk = ~clk;

    showcyc_mirror #(.ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW), .REQ_MIN(2)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .lb_valid(lb_valid), .lb_we(lb_we), .lb_size(lb_size), .lb_addr(lb_addr),
        .lb_data(lb_data), .lb_aack(lb_aack), .lb_dack(lb_dack), .lb_retry(lb_retry),
        .lb_hold(lb_hold), .ub_gnt(ub_gnt), .ub_noshow(ub_noshow), .ub_req(ub_req),
        .ub_aphase(ub_aphase), .ub_dphase(ub_dphase), .ub_addr(ub_addr), .ub_we(ub_we),
        .ub_size(ub_size), .ub_data(ub_data)
    );

    function automatic bit shows(input logic [1:0] m, input logic we);
        return (m == 2'b00) || (m == 2'b01 && we);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Unified-bus responder in random mode
    always @(negedge clk) begin
        if (bus_rand) begin
            ub_gnt    = ($urandom % 3) != 0;
            ub_noshow = ($urandom % 10) == 0;
        end
    end

    // Show-cycle monitor, sampled just after the falling edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (prev_ns) chk(!ub_req && !ub_aphase, "R9", "bus released after no-show", {ub_req, ub_aphase}, 0);
            if (dpend) begin
                chk(ub_dphase, "R8", "data phase follows address phase", ub_dphase, 1);
                if (ub_dphase) chk(ub_data == cur.d, "R2", "shown data", ub_data, cur.d);
                dpend = 1'b0;
            end else if (ub_dphase) begin
                chk(1'b0, "R8", "data phase without address phase", 1, 0);
            end
            if (ub_aphase) begin
                chk(req_run >= 2, "R7", "request length before address phase", req_run, 2);
                chk(lb_hold, "R5", "local bus held during show", lb_hold, 1);
                if (!ub_noshow) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4", "unexpected show cycle", ub_addr, 0);
                    end else begin
                        cur = exp_q.pop_front();
                        chk(ub_addr == cur.a && ub_we == cur.we && ub_size == cur.sz, "R2",
                            "shown address/dir/size", {ub_addr, ub_we, ub_size}, {cur.a, cur.we, cur.sz});
                        dpend = 1'b1;
                    end
                end
            end
            req_run = ub_req ? req_run + 1 : 0;
            if (lb_hold) hold_cycles++;
            prev_ns = (ub_req || ub_aphase) && ub_noshow;
        end
    end

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m;
        @(negedge clk);
        cfg_we = 1'b0;
        mode_model = m;
    endtask

    task automatic lb_access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [SW-1:0] sz, input int adly, input int ddly, input bit rty);
        bit q;
        while (lb_hold) @(negedge clk);
        q = shows(mode_model, we);
        lb_valid = 1'b1; lb_we = we; lb_addr = a; lb_data = d; lb_size = sz;
        for (int i = 0; i < adly; i++) @(negedge clk);
        if (rty) begin
            lb_retry = 1'b1;
            @(negedge clk);
            lb_retry = 1'b0; lb_valid = 1'b0;
            @(negedge clk);
            return;
        end
        lb_aack = 1'b1;
        if (q) exp_q.push_back('{a: a, we: we, sz: sz, d: d});
        if (ddly == 0) begin
            lb_dack = 1'b1;
            @(negedge clk);
        end else begin
            @(negedge clk);
            lb_aack = 1'b0;
            for (int i = 1; i < ddly; i++) @(negedge clk);
            lb_dack = 1'b1;
            @(negedge clk);
        end
        lb_aack = 1'b0; lb_dack = 1'b0; lb_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            if (exp_q.size() == 0 && !lb_hold && !dpend) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk({lb_hold, ub_req, ub_aphase, ub_dphase} == 4'b0, "R1", "outputs after reset",
            {lb_hold, ub_req, ub_aphase, ub_dphase}, 0);

        // R1: default mode is off
        hold_cycles = 0;
        lb_access(1'b1, 16'h1234, 16'hBEEF, 2'd2, 0, 0, 1'b0);
        lb_access(1'b0, 16'h0042, 16'h0007, 2'd1, 1, 1, 1'b0);
        repeat (4) @(negedge clk);
        chk(hold_cycles == 0, "R1", "no hold before mode write", hold_cycles, 0);

        // R4: reserved and off codes
        set_mode(2'b10);
        hold_cycles = 0;
        lb_access(1'b1, 16'h2222, 16'h3333, 2'd0, 0, 0, 1'b0);
        lb_access(1'b0, 16'h4444, 16'h5555, 2'd3, 2, 0, 1'b0);
        set_mode(2'b11);
        lb_access(1'b1, 16'h6666, 16'h7777, 2'd1, 1, 2, 1'b0);
        repeat (4) @(negedge clk);
        chk(hold_cycles == 0, "R4", "no hold in modes 10/11", hold_cycles, 0);

        // R11: shortest path, grant held high
        set_mode(2'b00);
        ub_gnt = 1'b1; ub_noshow = 1'b0;
        @(negedge clk);
        lb_valid = 1'b1; lb_we = 1'b1; lb_addr = 16'hA5A5; lb_data = 16'h5A5A; lb_size = 2'd2;
        lb_aack = 1'b1; lb_dack = 1'b1;
        exp_q.push_back('{a: 16'hA5A5, we: 1'b1, sz: 2'd2, d: 16'h5A5A});
        @(posedge clk); #1;
        chk(lb_hold && ub_req, "R11", "edge 1: hold and request", {lb_hold, ub_req}, 3);
        @(negedge clk);
        lb_valid = 1'b0; lb_aack = 1'b0; lb_dack = 1'b0;
        @(posedge clk); #1;
        chk(ub_req && !ub_aphase, "R11", "edge 2: still requesting", {ub_req, ub_aphase}, 2);
        @(posedge clk); #1;
        chk(ub_aphase, "R11", "edge 3: address phase", ub_aphase, 1);
        @(posedge clk); #1;
        chk(ub_dphase, "R11", "edge 4: data phase", ub_dphase, 1);
        @(posedge clk); #1;
        chk(!lb_hold, "R11", "edge 5: local bus released", lb_hold, 0);
        wait_idle();

        // R2: reads and writes in mode 00, late acknowledges
        lb_access(1'b0, 16'h0100, 16'hC0DE, 2'd1, 0, 0, 1'b0);
        lb_access(1'b1, 16'h0200, 16'hFACE, 2'd3, 2, 1, 1'b0);
        lb_access(1'b0, 16'h0300, 16'h0BAD, 2'd0, 1, 3, 1'b0);
        wait_idle();
        chk(exp_q.size() == 0, "R2", "all mode-00 accesses shown", exp_q.size(), 0);

        // R6: retry from a waiting address phase, then from the first cycle
        hold_cycles = 0;
        lb_access(1'b1, 16'h0400, 16'h1111, 2'd2, 1, 0, 1'b1);
        repeat (3) @(negedge clk);
        chk(hold_cycles == 2, "R6", "hold after late retry", hold_cycles, 2);
        hold_cycles = 0;
        lb_access(1'b1, 16'h0500, 16'h2222, 2'd2, 0, 0, 1'b1);
        repeat (3) @(negedge clk);
        chk(hold_cycles == 1, "R6", "hold after first-cycle retry", hold_cycles, 1);
        lb_access(1'b1, 16'h0500, 16'h2222, 2'd2, 0, 0, 1'b0);
        wait_idle();
        chk(exp_q.size() == 0, "R6", "acknowledged retry shown once", exp_q.size(), 0);

        // R3: writes only
        set_mode(2'b01);
        hold_cycles = 0;
        lb_access(1'b0, 16'h0600, 16'h3333, 2'd1, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk(hold_cycles == 0, "R3", "quick read not held", hold_cycles, 0);
        hold_cycles = 0;
        lb_access(1'b0, 16'h0700, 16'h4444, 2'd1, 2, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk(hold_cycles == 2, "R3", "late read held until acknowledge", hold_cycles, 2);
        lb_access(1'b1, 16'h0800, 16'h5555, 2'd0, 0, 0, 1'b0);
        wait_idle();
        chk(exp_q.size() == 0, "R3", "write shown in mode 01", exp_q.size(), 0);

        // R9: refusal during request
        set_mode(2'b00);
        ub_gnt = 1'b0;
        lb_access(1'b1, 16'h0900, 16'h6666, 2'd3, 0, 0, 1'b0);
        ub_noshow = 1'b1;
        @(negedge clk);
        ub_noshow = 1'b0; ub_gnt = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0, "R9", "refused show retried and shown", exp_q.size(), 0);

        // R10: mode write while a show is pending
        ub_gnt = 1'b0;
        lb_access(1'b1, 16'h0A00, 16'h7777, 2'd2, 0, 0, 1'b0);
        set_mode(2'b11);
        ub_gnt = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0, "R10", "pending show completes after mode write", exp_q.size(), 0);
        hold_cycles = 0;
        lb_access(1'b1, 16'h0B00, 16'h8888, 2'd2, 0, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk(hold_cycles == 0, "R10", "new mode applies to next access", hold_cycles, 0);

        // Random phase
        bus_rand = 1'b1;
        for (int k = 0; k < 300; k++) begin
            if ($urandom % 16 == 0) set_mode(2'($urandom % 4));
            lb_access(1'($urandom), 16'($urandom), 16'($urandom), 2'($urandom),
                      int'($urandom % 3), int'($urandom % 3), ($urandom % 8) == 0);
        end
        bus_rand = 1'b0;
        @(negedge clk);
        ub_gnt = 1'b1; ub_noshow = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0, "R2", "random accesses all shown", exp_q.size(), 0);
        summary();
    end
endmodule